// File: doc/BRIEF.md
# Audio De-emphasis Shelving Filter

This block restores the treble balance of PCM audio that was recorded with pre-emphasis. It is a first-order IIR shelf. Its pole is set by a 50 µs time constant, with a corner near 3.18 kHz. Its zero is set by a 15 µs time constant, with a corner near 10.6 kHz. Low frequencies pass at 0 dB. Between the two corners the gain falls along a single first-order slope. Above the upper corner it settles on a shelf about 10 dB down. The coefficients are fixed Q2.22 constants, obtained from the bilinear transform of the analog response. One set is stored for each of three sample rates, and a two-bit selector picks the set.

Samples are signed 24-bit values and move through valid/ready handshakes on both sides. The block holds one output register. A sample is taken whenever `in_valid` and `in_ready` are both high. The result appears on the next cycle, and it is held there until the downstream side takes it with `out_ready`. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so back-pressure passes straight upstream without extra buffering. The block can also be bypassed, either through the enable pin or through the fourth selector code. In bypass, each sample is copied unchanged with the same one-cycle latency.

Top module: `deemph_filter`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. A sample is accepted on a cycle where `in_valid && in_ready`, and `out_valid` is high on the following cycle. `out_valid` falls only after a cycle with `out_ready` high and no acceptance.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_sat` keep their values.
- R3: In filter mode the output for accepted sample x is y = (b0·x + b1·x1 − a1·y1 + 2^21) >>> 22. Here x1 and y1 are the previous accepted input and output, and the shift is arithmetic. The integer coefficients are: code 0 (32 kHz) b0=1957342, b1=39946, a1=−2197016; code 1 (44.1 kHz) b0=1800992, b1=−250418, a1=−2643730; code 2 (48 kHz) b0=1764500, b1=−318188, a1=−2747992.
- R4: A constant input held long enough makes the output settle to within 1 LSB of that input (unity gain at DC).
- R5: An input that alternates between +A and −A settles to an output magnitude of 0.3·A ±1% at every rate code (a shelf of about −10.5 dB at half the sample rate).
- R6: Results outside the signed 24-bit range are clamped to 8388607 or −8388608 and never wrap. `out_sat` is high exactly when such a clamp occurred for the sample shown. Full-scale steady inputs stay within 1 LSB of the input, with the same sign.
- R7: With `enable` low, an accepted sample appears unchanged on `out_data` one cycle later, with `out_sat` low.
- R8: Rate code 3 bypasses the filter in the same way as `enable` low.
- R9: During bypass the filter history is held at zero. The first filtered sample x after bypass ends gives (b0·x + 2^21) >>> 22.
- R10: Any change of `rate_sel` clears the filter history. The first sample accepted on or after the cycle of change gives (b0·x + 2^21) >>> 22 with the new code's b0.
- R11: While `rst_n` is low, `out_valid`, `out_data`, `out_sat` and the filter history are zero, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | High to filter, low to pass samples through |
| rate_sel | input | 2 | Coefficient set: 0 = 32 kHz, 1 = 44.1 kHz, 2 = 48 kHz, 3 = bypass |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 24 | Signed input sample |
| out_valid | output | 1 | Output sample present |
| out_ready | input | 1 | Downstream takes the output sample this cycle |
| out_data | output | 24 | Signed output sample |
| out_sat | output | 1 | Output sample was clamped to the 24-bit range |

## Verification
The bypass-copy assertion compares `out_data` with the input of the previous cycle. It therefore assumes that `enable` and `rate_sel` were constant over that acceptance. The handshake properties assume that `in_valid` and `out_ready` are known values after reset. The stimulus changes `enable` and `rate_sel` only while the stream is idle and the output has drained. It drives every input on the falling clock edge. It also applies a periodic `out_ready` stall pattern, so that the hold and back-pressure rules are exercised in each test phase.

// File: rtl/deemph_pkg.sv
package deemph_pkg;

  localparam int SAMPLE_W = 24;
  localparam int COEF_W   = 24;
  localparam int FRAC_W   = 22;

  typedef enum logic [1:0] {
    RATE_32K   = 2'd0,
    RATE_44K1  = 2'd1,
    RATE_48K   = 2'd2,
    RATE_THRU  = 2'd3
  } rate_e;

  typedef struct packed {
    logic signed [COEF_W-1:0] b0;
    logic signed [COEF_W-1:0] b1;
    logic signed [COEF_W-1:0] a1;
  } coef_t;

  // Q2.22 sets from the bilinear map of (1 + s*15us) / (1 + s*50us);
  // b0 + b1 == 1 + a1 in every set, so DC gain is exact.
  localparam coef_t COEF_32K  = '{b0:  24'sd1957342, b1:  24'sd39946,  a1: -24'sd2197016};
  localparam coef_t COEF_44K1 = '{b0:  24'sd1800992, b1: -24'sd250418, a1: -24'sd2643730};
  localparam coef_t COEF_48K  = '{b0:  24'sd1764500, b1: -24'sd318188, a1: -24'sd2747992};

endpackage

// File: rtl/deemph_coef_sel.sv
module deemph_coef_sel
  import deemph_pkg::*;
(
  input  logic        enable,
  input  logic [1:0]  rate_sel,
  output coef_t       coef,
  output logic        bypass
);

  always_comb begin
    coef   = '0;
    bypass = !enable;
    case (rate_e'(rate_sel))
      RATE_32K:  coef = COEF_32K;
      RATE_44K1: coef = COEF_44K1;
      RATE_48K:  coef = COEF_48K;
      default:   bypass = 1'b1;   // R8: fourth code passes samples through
    endcase
  end

endmodule

// File: rtl/deemph_mac.sv
module deemph_mac #(
  parameter int DATA_W        = 24,
  parameter int COEF_W        = 24,
  parameter int FRAC_W        = 22,
  parameter bit ROUND_NEAREST = 1'b1
) (
  input  logic signed [DATA_W-1:0] x,
  input  logic signed [DATA_W-1:0] x1,
  input  logic signed [DATA_W-1:0] y1,
  input  logic signed [COEF_W-1:0] b0,
  input  logic signed [COEF_W-1:0] b1,
  input  logic signed [COEF_W-1:0] a1,
  output logic signed [DATA_W-1:0] y,
  output logic                     sat
);

  localparam int AW = DATA_W + COEF_W + 2;
  localparam logic signed [AW-1:0] TOP_V =
    {{(AW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [AW-1:0] BOT_V =
    {{(AW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [AW-1:0] HALF_LSB =
    {{(AW-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic signed [AW-1:0] xw, x1w, y1w, b0w, b1w, a1w;
  logic signed [AW-1:0] acc, acc_r, scaled;

  always_comb begin
    xw  = AW'(x);
    x1w = AW'(x1);
    y1w = AW'(y1);
    b0w = AW'(b0);
    b1w = AW'(b1);
    a1w = AW'(a1);
    acc = (xw * b0w) + (x1w * b1w) - (y1w * a1w);
  end

  generate
    if (ROUND_NEAREST) begin : g_round
      assign acc_r = acc + HALF_LSB;
    end else begin : g_trunc
      assign acc_r = acc;
    end
  endgenerate

  assign scaled = acc_r >>> FRAC_W;

  always_comb begin
    sat = 1'b0;
    y   = scaled[DATA_W-1:0];
    if (scaled > TOP_V) begin
      sat = 1'b1;
      y   = TOP_V[DATA_W-1:0];
    end else if (scaled < BOT_V) begin
      sat = 1'b1;
      y   = BOT_V[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/deemph_history.sv
module deemph_history #(
  parameter int DATA_W = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               rate_sel,
  input  logic                     bypass,
  input  logic                     take,
  input  logic signed [DATA_W-1:0] x_new,
  input  logic signed [DATA_W-1:0] y_new,
  output logic signed [DATA_W-1:0] x1_use,
  output logic signed [DATA_W-1:0] y1_use
);

  logic signed [DATA_W-1:0] x1_q, y1_q;
  logic [1:0]               rate_q;
  logic                     rate_moved;

  assign rate_moved = (rate_sel != rate_q);
  assign x1_use     = rate_moved ? '0 : x1_q;
  assign y1_use     = rate_moved ? '0 : y1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1_q   <= '0;
      y1_q   <= '0;
      rate_q <= '0;
    end else begin
      rate_q <= rate_sel;
      if (bypass) begin
        x1_q <= '0;
        y1_q <= '0;
      end else if (take) begin
        x1_q <= x_new;
        y1_q <= y_new;
      end else if (rate_moved) begin
        x1_q <= '0;
        y1_q <= '0;
      end
    end
  end

endmodule

// File: rtl/deemph_filter.sv
module deemph_filter
  import deemph_pkg::*;
#(
  parameter int DATA_W = SAMPLE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [1:0]               rate_sel,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     out_sat
);

  coef_t                    coef;
  logic                     bypass;
  logic                     take;
  logic signed [DATA_W-1:0] x1_use, y1_use, y_calc;
  logic                     sat_calc;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  deemph_coef_sel u_coef (
    .enable   (enable),
    .rate_sel (rate_sel),
    .coef     (coef),
    .bypass   (bypass)
  );

  deemph_history #(.DATA_W(DATA_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .bypass   (bypass),
    .take     (take),
    .x_new    (in_data),
    .y_new    (y_calc),
    .x1_use   (x1_use),
    .y1_use   (y1_use)
  );

  deemph_mac #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .FRAC_W (FRAC_W)
  ) u_mac (
    .x   (in_data),
    .x1  (x1_use),
    .y1  (y1_use),
    .b0  (coef.b0),
    .b1  (coef.b1),
    .a1  (coef.a1),
    .y   (y_calc),
    .sat (sat_calc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sat   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= bypass ? in_data : y_calc;
      out_sat   <= bypass ? 1'b0 : sat_calc;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/deemph_filter_chk.sv
module deemph_filter_chk #(
  parameter int DATA_W = 24
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     enable,
  input logic [1:0]               rate_sel,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic signed [DATA_W-1:0] in_data,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [DATA_W-1:0] out_data,
  input logic                     out_sat
);

  localparam logic signed [DATA_W-1:0] RAIL_HI = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] RAIL_LO = {1'b1, {(DATA_W-1){1'b0}}};

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);  // R1

  AST_DRAIN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid);  // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sat));  // R2

  AST_SAT_ON_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sat |-> (out_data == RAIL_HI || out_data == RAIL_LO));  // R6

  AST_THRU_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (!enable || rate_sel == 2'b11)
      |=> out_data == $past(in_data) && !out_sat);  // R7

endmodule

bind deemph_filter deemph_filter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .rate_sel  (rate_sel),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sat   (out_sat)
);

// File: tb/deemph_filter_tb.sv
module deemph_filter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam longint HI = 8388607;
  localparam longint LO = -8388608;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               enable = 1'b1;
  logic [1:0]         rate_sel = 2'd2;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic signed [23:0] in_data = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic signed [23:0] out_data;
  logic               out_sat;

  int total = 0;
  int bad = 0;
  bit stall_en = 1'b0;
  int stall_cnt = 0;

  longint B0 [3] = '{1957342, 1800992, 1764500};
  longint B1 [3] = '{39946, -250418, -318188};
  longint A1 [3] = '{-2197016, -2643730, -2747992};

  // reference model state
  bit     m_v = 0;
  longint m_d = 0;
  bit     m_s = 0;
  longint m_x1 = 0, m_y1 = 0;
  int     m_rate = 0;
  longint last_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  deemph_filter dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rate_sel(rate_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sat(out_sat)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint first_out(input int r, input longint x);
    return (B0[r] * x + 64'sd2097152) >>> 22;
  endfunction

  function automatic longint absl(input longint v);
    return (v < 0) ? -v : v;
  endfunction

  // per-clock comparison, then model update
  always @(posedge clk) begin
    if (!rst_n) begin
      m_v = 0; m_d = 0; m_s = 0; m_x1 = 0; m_y1 = 0; m_rate = 0;
    end else begin
      bit acc_now, byp, chg;
      longint ex1, ey1, x, a, y;
      int r;
      check(out_valid == m_v, "R1 out_valid", longint'(out_valid), longint'(m_v));
      check(in_ready == (!m_v || out_ready), "R1 in_ready", longint'(in_ready),
            longint'(!m_v || out_ready));
      if (m_v) begin
        check(longint'(out_data) == m_d, "R3 out_data", longint'(out_data), m_d);
        check(out_sat == m_s, "R6 out_sat", longint'(out_sat), longint'(m_s));
        if (out_ready) last_out = m_d;
      end
      acc_now = in_valid && (!m_v || out_ready);
      byp = !enable || (rate_sel == 2'd3);
      chg = (int'(rate_sel) != m_rate);
      ex1 = chg ? 0 : m_x1;
      ey1 = chg ? 0 : m_y1;
      x = longint'(in_data);
      r = int'(rate_sel);
      if (acc_now) begin
        m_v = 1;
        if (byp) begin
          m_d = x; m_s = 0;
        end else begin
          a = B0[r] * x + B1[r] * ex1 - A1[r] * ey1 + 64'sd2097152;
          y = a >>> 22;
          m_s = 0;
          if (y > HI) begin y = HI; m_s = 1; end
          if (y < LO) begin y = LO; m_s = 1; end
          m_d = y;
        end
      end else if (out_ready) begin
        m_v = 0;
      end
      if (byp) begin
        m_x1 = 0; m_y1 = 0;
      end else if (acc_now) begin
        m_x1 = x; m_y1 = m_d;
      end else if (chg) begin
        m_x1 = 0; m_y1 = 0;
      end
      m_rate = r;
    end
  end

  task automatic set_ready();
    if (stall_en) out_ready = (stall_cnt % 4 != 2);
    else out_ready = 1'b1;
    stall_cnt++;
  endtask

  task automatic push(input longint x);
    @(negedge clk);
    in_data = 24'(x);
    in_valid = 1'b1;
    set_ready();
    #1;
    while (!in_ready) begin
      @(negedge clk);
      set_ready();
      #1;
    end
    @(posedge clk);
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_mode(input bit en, input logic [1:0] r);
    @(negedge clk);
    enable = en;
    rate_sel = r;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    longint hold_d;
    repeat (3) @(negedge clk);
    // R11: reset state
    check(out_valid == 1'b0, "R11 out_valid", longint'(out_valid), 0);
    check(out_data == '0, "R11 out_data", longint'(out_data), 0);
    check(out_sat == 1'b0, "R11 out_sat", longint'(out_sat), 0);
    check(in_ready == 1'b1, "R11 in_ready", longint'(in_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11/R3: first sample after reset sees zero history
    push(1000000); drain();
    check(last_out == first_out(2, 1000000), "R11 first sample", last_out, first_out(2, 1000000));

    // R2 / R1: hold under back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 24'sd123456;
    @(negedge clk);
    in_valid = 1'b0;
    hold_d = longint'(out_data);
    repeat (3) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R2 valid held", longint'(out_valid), 1);
      check(longint'(out_data) == hold_d, "R2 data held", longint'(out_data), hold_d);
      check(in_ready == 1'b0, "R1 ready low", longint'(in_ready), 0);
    end
    out_ready = 1'b1;
    drain();

    // R4: DC gain at two rates
    stall_en = 1'b1;
    for (int k = 0; k < 2; k++) begin
      int r = (k == 0) ? 2 : 0;
      set_mode(1'b1, 2'(r));
      for (int i = 0; i < 300; i++) push(3000000);
      drain();
      check(absl(last_out - 3000000) <= 1, "R4 dc gain", last_out, 3000000);
    end

    // R10: rate change clears history
    set_mode(1'b1, 2'd1);
    push(500000); drain();
    check(last_out == first_out(1, 500000), "R10 cleared on change", last_out, first_out(1, 500000));

    // R5: near-Nyquist shelf at each rate
    for (int r = 0; r < 3; r++) begin
      set_mode(1'b1, 2'(3 - r));
      set_mode(1'b1, 2'(r));
      for (int i = 0; i < 200; i++) push((i % 2 == 0) ? 4000000 : -4000000);
      drain();
      check(absl(last_out) >= 1188000 && absl(last_out) <= 1212000, "R5 shelf gain",
            absl(last_out), 1200000);
    end

    // R7: enable low passes samples unchanged
    set_mode(1'b0, 2'd2);
    for (int i = 0; i < 4; i++) begin
      longint v = (i == 0) ? LO : (i == 1) ? HI : (i == 2) ? -77 : 4242;
      push(v); drain();
      check(last_out == v, "R7 bypass copy", last_out, v);
    end

    // R9: history zero after bypass
    set_mode(1'b1, 2'd2);
    push(2000000); drain();
    check(last_out == first_out(2, 2000000), "R9 zero history", last_out, first_out(2, 2000000));

    // R8: code 3 bypasses
    set_mode(1'b1, 2'd3);
    push(-654321); drain();
    check(last_out == -654321, "R8 code3 bypass", last_out, -654321);
    set_mode(1'b1, 2'd0);
    push(-700000); drain();
    check(last_out == first_out(0, -700000), "R10 after code3", last_out, first_out(0, -700000));

    // R6: full-scale inputs never wrap
    set_mode(1'b1, 2'd2);
    for (int i = 0; i < 300; i++) push(LO);
    drain();
    check(last_out < 0 && last_out <= LO + 1, "R6 negative rail", last_out, LO);
    for (int i = 0; i < 300; i++) push(HI);
    drain();
    check(last_out > 0 && last_out >= HI - 1, "R6 positive rail", last_out, HI);

    finish_run();
  end

endmodule